// File: doc/BRIEF.md
# Folded Gaussian Frequency-Trajectory Generator

This block turns a serial NRZ bit stream into the sequence of signed frequency-offset words that steer a phase-accumulator synthesizer so it emits GMSK with a Gaussian bandwidth-time product of 0.3. The offset is added to a per-carrier frequency word outside the block. The full deviation of ±512 corresponds to a quarter of the bit rate for a 16-bit accumulator. Each bit period is cut into 32 samples, one per sample tick.

The trajectory for a bit depends on that bit and its two neighbours. Three registered bits hold the previous, current and next bit, and the eight neighbour patterns are served from only two stored 32-entry curves: a ramp for a single transition and a bump for an isolated bit. To do this the block inverts the pattern when the current bit is 0, picks the page from the XOR of the folded neighbours, reverses the read direction when the folded previous bit is 1, and negates the result when the current bit is 0. The two all-equal patterns are not stored and give a constant full deviation.

The source of the bits loads a one-bit staging register with a strobe. The block asks for the next bit with a one-cycle request pulse each time the sample counter wraps.

Top module: `gtraj_gen`

## Requirements
- R1: After reset the three history bits (previous, current, next) and the staging bit are all 1, the sample counter is 0, `offset_o` is +512 and `bit_req_o` is 0.
- R2: The sample counter and the history bits change only on a clock with `smp_tick_i` high. With no tick, `offset_o` holds its value.
- R3: On a tick with the counter at 31, the counter returns to 0 and the history shifts: the new previous bit is the old current bit, the new current bit is the old next bit, and the new next bit is the staging bit. `bit_req_o` is high for exactly the one clock after that edge and low at all other times.
- R4: A clock with `bit_vld_i` high loads `bit_i` into the staging bit. Without the strobe the staging bit keeps its value, so the last bit supplied is repeated.
- R5: History 111 (previous, current, next) gives a constant +512 for all 32 samples. History 000 gives a constant −512.
- R6: History 011 gives +ramp[s] at sample s, and history 110 gives +ramp[31−s]. Here ramp = 0,30,60,90,120,149,178,205,232,257,282,305,327,347,366,384,401,416,429,442,453,463,472,480,487,493,498,502,506,508,510,512.
- R7: History 010 gives +bump[s] and history 101 gives −bump[s]. For s<16, bump[s] = 0,26,51,77,102,123,148,169,184,200,215,230,241,246,251,256, and bump[s] = bump[31−s] for s≥16.
- R8: When the current bit is 0, the output mirrors the inverted history. History 100 gives −ramp[s] and history 001 gives −ramp[31−s].
- R9: `offset_o` is an 11-bit two's-complement value that stays within −512 to +512. It shows the sample selected by a tick two clocks after the edge that takes the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld_i | input | 1 | Strobe that loads `bit_i` into the staging bit |
| bit_i | input | 1 | Data bit to be modulated |
| smp_tick_i | input | 1 | Advances the trajectory by one sample |
| offset_o | output | 11 | Signed frequency offset, registered |
| bit_req_o | output | 1 | One-clock request for the next data bit |

## Verification
The bench feeds a pattern prefix and then a maximal-length pseudo-random sequence, so every one of the eight neighbour patterns appears with many different predecessors. It checks every one of the 32 samples against a table written per pattern, not against the folding rules. A wrong fold would show up as mirrored or sign-flipped samples: for example a decoder that forgets to invert for a 0 current bit would give +ramp where −ramp is expected for 100. Reversing the wrong neighbour would swap the 011 and 110 curves. Pauses in the tick stream and bits that are left out of the strobe sequence check that the output holds still and that the last bit is repeated. The request pulse is checked at every tick to catch an off-by-one in the wrap.

// File: rtl/gtraj_pkg.sv
package gtraj_pkg;

  localparam int SMP_W = 5;
  localparam int N_SMP = 32;
  localparam int MAG_W = 10;
  localparam int PEAK  = 512;

  typedef struct packed {
    logic page;  // 1: ramp page, 0: bump page
    logic rev;   // read samples from last to first
    logic neg;   // negate the magnitude
    logic flat;  // constant full deviation, no table read
  } fold_t;

  // Single-transition curve, sample 0 at the bit edge.
  function automatic logic [MAG_W-1:0] ramp_val(input int unsigned i);
    logic [MAG_W-1:0] v;
    case (i)
      0:  v = 10'd0;    1:  v = 10'd30;   2:  v = 10'd60;   3:  v = 10'd90;
      4:  v = 10'd120;  5:  v = 10'd149;  6:  v = 10'd178;  7:  v = 10'd205;
      8:  v = 10'd232;  9:  v = 10'd257;  10: v = 10'd282;  11: v = 10'd305;
      12: v = 10'd327;  13: v = 10'd347;  14: v = 10'd366;  15: v = 10'd384;
      16: v = 10'd401;  17: v = 10'd416;  18: v = 10'd429;  19: v = 10'd442;
      20: v = 10'd453;  21: v = 10'd463;  22: v = 10'd472;  23: v = 10'd480;
      24: v = 10'd487;  25: v = 10'd493;  26: v = 10'd498;  27: v = 10'd502;
      28: v = 10'd506;  29: v = 10'd508;  30: v = 10'd510;  default: v = 10'd512;
    endcase
    return v;
  endfunction

  // Isolated-bit curve: first half stored, second half mirrored.
  function automatic logic [MAG_W-1:0] bump_val(input int unsigned i);
    int unsigned j;
    logic [MAG_W-1:0] v;
    j = (i < 16) ? i : 31 - i;
    case (j)
      0:  v = 10'd0;    1:  v = 10'd26;   2:  v = 10'd51;   3:  v = 10'd77;
      4:  v = 10'd102;  5:  v = 10'd123;  6:  v = 10'd148;  7:  v = 10'd169;
      8:  v = 10'd184;  9:  v = 10'd200;  10: v = 10'd215;  11: v = 10'd230;
      12: v = 10'd241;  13: v = 10'd246;  14: v = 10'd251;  default: v = 10'd256;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/gtraj_tribit.sv
module gtraj_tribit #(
  parameter int SMP_W = gtraj_pkg::SMP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             smp_tick_i,
  output logic [SMP_W-1:0] cnt_o,
  output logic [2:0]       hist_o,   // {previous, current, next}
  output logic             bit_req_o
);
  localparam logic [SMP_W-1:0] LAST = '1;

  logic stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q   <= 1'b1;
      hist_o    <= 3'b111;
      cnt_o     <= '0;
      bit_req_o <= 1'b0;
    end else begin
      bit_req_o <= 1'b0;
      if (bit_vld_i) stage_q <= bit_i;
      if (smp_tick_i) begin
        if (cnt_o == LAST) begin
          cnt_o     <= '0;
          hist_o    <= {hist_o[1], hist_o[0], stage_q};
          bit_req_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gtraj_fold.sv
module gtraj_fold #(
  parameter int SMP_W = gtraj_pkg::SMP_W
) (
  input  logic [2:0]         hist_i,
  input  logic [SMP_W-1:0]   cnt_i,
  output gtraj_pkg::fold_t   ctl_o,
  output logic [SMP_W:0]     addr_o
);
  logic [2:0]       folded;
  logic [SMP_W-1:0] idx;

  always_comb begin
    folded     = hist_i[1] ? hist_i : ~hist_i;
    ctl_o.flat = folded[2] & folded[0];
    ctl_o.page = folded[2] ^ folded[0];
    ctl_o.rev  = folded[2];
    ctl_o.neg  = ~hist_i[1];
    idx        = ctl_o.rev ? ~cnt_i : cnt_i;
    addr_o     = {ctl_o.page, idx};
  end
endmodule

// File: rtl/gtraj_rom.sv
module gtraj_rom #(
  parameter int SMP_W = gtraj_pkg::SMP_W,
  parameter int MAG_W = gtraj_pkg::MAG_W
) (
  input  logic             clk,
  input  logic [SMP_W:0]   addr_i,
  output logic [MAG_W-1:0] data_o
);
  localparam int N_SMP = 1 << SMP_W;
  localparam int DEPTH = 2 * N_SMP;

  logic [MAG_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i >= N_SMP) mem[i] = MAG_W'(gtraj_pkg::ramp_val(i - N_SMP));
      else            mem[i] = MAG_W'(gtraj_pkg::bump_val(i));
    end
  end

  always_ff @(posedge clk) data_o <= mem[addr_i];
endmodule

// File: rtl/gtraj_gen.sv
module gtraj_gen #(
  parameter int SMP_W = gtraj_pkg::SMP_W,
  parameter int MAG_W = gtraj_pkg::MAG_W,
  parameter int PEAK  = gtraj_pkg::PEAK,
  localparam int OFS_W = MAG_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_vld_i,
  input  logic                    bit_i,
  input  logic                    smp_tick_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    bit_req_o
);
  localparam logic [MAG_W-1:0] PEAK_C = MAG_W'(PEAK);

  logic [SMP_W-1:0] cnt_q;
  logic [2:0]       hist_q;
  gtraj_pkg::fold_t ctl;
  logic [SMP_W:0]   rom_addr;
  logic [MAG_W-1:0] rom_q;
  logic             flat_q, neg_q;
  logic [MAG_W-1:0] mag;

  gtraj_tribit #(.SMP_W(SMP_W)) u_tribit (
    .clk(clk), .rst(rst), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .smp_tick_i(smp_tick_i), .cnt_o(cnt_q), .hist_o(hist_q),
    .bit_req_o(bit_req_o)
  );

  gtraj_fold #(.SMP_W(SMP_W)) u_fold (
    .hist_i(hist_q), .cnt_i(cnt_q), .ctl_o(ctl), .addr_o(rom_addr)
  );

  gtraj_rom #(.SMP_W(SMP_W), .MAG_W(MAG_W)) u_rom (
    .clk(clk), .addr_i(rom_addr), .data_o(rom_q)
  );

  // Control flags travel alongside the table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      flat_q <= 1'b1;
      neg_q  <= 1'b0;
    end else begin
      flat_q <= ctl.flat;
      neg_q  <= ctl.neg;
    end
  end

  assign mag = flat_q ? PEAK_C : rom_q;

  always_ff @(posedge clk) begin
    if (rst) offset_o <= $signed({1'b0, PEAK_C});
    else if (neg_q) offset_o <= -$signed({1'b0, mag});
    else offset_o <= $signed({1'b0, mag});
  end
endmodule

// File: rtl/gtraj_chk.sv
module gtraj_chk #(
  parameter int SMP_W = 5,
  parameter int OFS_W = 11,
  parameter int PEAK  = 512
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    smp_tick_i,
  input logic                    bit_req_o,
  input logic signed [OFS_W-1:0] offset_o,
  input logic [SMP_W-1:0]        cnt_q,
  input logic [2:0]              hist_q
);
  localparam logic [SMP_W-1:0] LAST = '1;
  localparam logic signed [OFS_W-1:0] P_POS = OFS_W'(PEAK);
  localparam logic signed [OFS_W-1:0] P_NEG = -OFS_W'(PEAK);

  p_offset_range_r9: assert property (@(posedge clk) disable iff (rst)
    (offset_o <= P_POS) && (offset_o >= P_NEG));

  p_wrap_req_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_tick_i && cnt_q == LAST) |=> (bit_req_o && cnt_q == '0));

  p_req_only_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    !(smp_tick_i && cnt_q == LAST) |=> !bit_req_o);

  p_hist_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_tick_i && cnt_q == LAST) |=> (hist_q[2:1] == $past(hist_q[1:0])));

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_tick_i |=> ($stable(cnt_q) && $stable(hist_q)));

  p_flat_high_r5: assert property (@(posedge clk) disable iff (rst)
    (hist_q == 3'b111) |-> ##2 (offset_o == P_POS));

  p_flat_low_r5: assert property (@(posedge clk) disable iff (rst)
    (hist_q == 3'b000) |-> ##2 (offset_o == P_NEG));
endmodule

bind gtraj_gen gtraj_chk #(.SMP_W(SMP_W), .OFS_W(OFS_W), .PEAK(PEAK)) u_chk (
  .clk(clk), .rst(rst), .smp_tick_i(smp_tick_i), .bit_req_o(bit_req_o),
  .offset_o(offset_o), .cnt_q(cnt_q), .hist_q(hist_q)
);

// File: tb/test_gtraj_gen.sv
`timescale 1ns/1ps
module test_gtraj_gen;
  logic clk = 0, rst = 1, bit_vld_i = 0, bit_i = 0, smp_tick_i = 0;
  logic signed [10:0] offset_o;
  logic bit_req_o;

  gtraj_gen i_gtraj_gen (
    .clk(clk), .rst(rst), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .smp_tick_i(smp_tick_i), .offset_o(offset_o), .bit_req_o(bit_req_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // Reference model state
  bit m_prev = 1, m_cur = 1, m_nxt = 1, m_stage = 1;
  int m_cnt = 0;

  int ramp_t [32] = '{0,30,60,90,120,149,178,205,232,257,282,305,327,347,366,384,
                      401,416,429,442,453,463,472,480,487,493,498,502,506,508,510,512};
  int bump_h [16] = '{0,26,51,77,102,123,148,169,184,200,215,230,241,246,251,256};

  function automatic int bump(int s);
    return (s < 16) ? bump_h[s] : bump_h[31 - s];
  endfunction

  function automatic int expect_ofs(bit p, bit c, bit n, int s);
    case ({p, c, n})
      3'b111: return 512;
      3'b000: return -512;
      3'b011: return ramp_t[s];
      3'b110: return ramp_t[31 - s];
      3'b010: return bump(s);
      3'b101: return -bump(s);
      3'b100: return -ramp_t[s];
      default: return -ramp_t[31 - s]; // 001
    endcase
  endfunction

  function automatic string tag_of(bit p, bit c, bit n);
    case ({p, c, n})
      3'b111, 3'b000: return "R5";
      3'b011, 3'b110: return "R6";
      3'b010, 3'b101: return "R7";
      default:        return "R8";
    endcase
  endfunction

  task automatic check(string req, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (hist %b%b%b sample %0d)",
               req, act, exp_v, m_prev, m_cur, m_nxt, m_cnt);
    end
  endtask

  task automatic strobe(bit b);
    @(negedge clk); bit_vld_i = 1; bit_i = b;
    @(negedge clk); bit_vld_i = 0;
    m_stage = b;
  endtask

  task automatic tick();
    bit wrap;
    @(negedge clk); smp_tick_i = 1;
    @(negedge clk); smp_tick_i = 0;
    wrap = (m_cnt == 31);
    if (wrap) begin
      m_prev = m_cur; m_cur = m_nxt; m_nxt = m_stage; m_cnt = 0;
    end else m_cnt++;
    check("R3 bit_req_o", int'(bit_req_o), int'(wrap));
    @(negedge clk);
    @(negedge clk);
    check({tag_of(m_prev, m_cur, m_nxt), " R9 offset"}, int'(offset_o),
          expect_ofs(m_prev, m_cur, m_nxt, m_cnt));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [6:0] lfsr = 7'h5a;
    bit prefix [12] = '{0,0,0,1,0,1,1,1,0,0,1,1};
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 offset after reset", int'(offset_o), 512);
    check("R1 bit_req_o after reset", int'(bit_req_o), 0);
    for (int i = 0; i < 140; i++) begin
      bit b;
      if (i < 12) b = prefix[i];
      else begin
        b = lfsr[6] ^ lfsr[5];
        lfsr = {lfsr[5:0], b};
      end
      // R4: some bits are not strobed, so the staging bit repeats
      if (i < 12 || (i % 9) != 4) strobe(b);
      for (int s = 0; s < 32; s++) begin
        tick();
        if (s == 10 && (i % 3) == 0) begin
          // R2: no tick, output must hold
          repeat (5) @(negedge clk);
          check("R2 hold without tick", int'(offset_o),
                expect_ofs(m_prev, m_cur, m_nxt, m_cnt));
        end
      end
    end
    // R4: a late strobe overrides an earlier one before the wrap
    strobe(1'b0);
    strobe(1'b1);
    for (int s = 0; s < 64; s++) tick();
    check("R4 last strobe wins", int'(m_stage), 1);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule